// File: doc/BRIEF.md
# Warp Barrier with Predicate Reduction

This unit holds back every warp of a thread block at a synchronisation point until all of them have reached it. The threads of one warp move in lockstep, so the unit records one arrival per warp rather than one per thread. Each arrival carries a warp number, a barrier kind, a predicate bit for each lane and a mask of the lanes that take part.

While warps are waiting, the unit folds their predicates into three running values: the number of active lanes with a true predicate, whether every active lane was true, and whether any active lane was true. When the last expected warp arrives, a one-cycle release pulse goes out together with the value chosen by the barrier kind. All waiting warps take that pulse as their signal to proceed.

The number of warps in the block is written at block launch. Two misuse cases are reported on sticky flags. In the first, warps wait with different barrier kinds, which on real hardware leads to a hang. In the second, a warp arrives twice before release.

Top module: `warp_barrier_reduce`

## Requirements
- R1: After reset, `release_o`, `result_o`, `mismatch_o` and `dup_o` are all 0, and the expected warp count is MAX_WARPS.
- R2: `release_o` is high for exactly the one cycle after the clock edge that accepts the last distinct expected warp. It is never high before all expected warps have arrived. `result_o` is 0 whenever `release_o` is low.
- R3: With barrier kind 2'b00 (count), the released result is the number of lanes, summed over all warps of the barrier, whose predicate and mask bits are both 1. The reserved kind 2'b11 behaves as count.
- R4: With barrier kind 2'b01 (all), the result is 1 when every lane with its mask bit set has a true predicate, and 0 otherwise. A barrier with no active lanes yields 1.
- R5: With barrier kind 2'b10 (any), the result is 1 when at least one lane with its mask bit set has a true predicate, and 0 otherwise.
- R6: A launch latches the expected warp count, with 0 raised to 1 and values above MAX_WARPS lowered to MAX_WARPS. A launch also discards pending arrivals and clears both error flags. An arrival in the same cycle as a launch is ignored.
- R7: An arrival whose barrier kind differs from the kind of warps already waiting sets `mismatch_o`, which stays set until the next launch. The arrival still counts, and the barrier keeps the kind of its first arrival.
- R8: A second arrival from a warp already waiting sets `dup_o`, which stays set until the next launch. That second arrival adds nothing to the result and does not count toward completion.
- R9: Arrival state clears in the release cycle. An arrival presented in the cycle that `release_o` is high counts toward the next barrier.
- R10: An arrival whose warp number is not below the launched warp count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Block launch strobe |
| launch_warps_i | input | $clog2(MAX_WARPS+1) | Warp count of the launched block |
| arr_valid_i | input | 1 | Warp arrival strobe |
| arr_warp_i | input | $clog2(MAX_WARPS) | Number of the arriving warp |
| arr_mode_i | input | 2 | Barrier kind: 00 count, 01 all, 10 any, 11 count |
| arr_pred_i | input | LANES | Per-lane predicate bits |
| arr_mask_i | input | LANES | Per-lane active mask |
| release_o | output | 1 | One-cycle release pulse |
| result_o | output | $clog2(MAX_WARPS*LANES+1) | Reduced value, valid with release |
| mismatch_o | output | 1 | Sticky flag: barrier kinds differed |
| dup_o | output | 1 | Sticky flag: duplicate warp arrival |

## Verification
The bench builds the unit with LANES=4 and MAX_WARPS=4. At that size every predicate and mask pattern of one warp can be swept against a derived partner pattern for all four barrier kinds, so each lane combination reaches the count, all and any paths, including barriers with no active lanes. Four warps in reverse arrival order exercise the full-block case. The same configuration also reaches the clamping of launch counts at both ends, out-of-range warp numbers, duplicate and mixed-kind arrivals, and an arrival in the release cycle. Expected values come from bit counting in the bench.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    typedef enum logic [1:0] {
        WBR_COUNT = 2'b00,
        WBR_ALL   = 2'b01,
        WBR_ANY   = 2'b10,
        WBR_RSVD  = 2'b11
    } wbr_kind_e;

endpackage

// File: rtl/wbr_lane_fold.sv
module wbr_lane_fold #(
    parameter int LANES = 32,
    localparam int PW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] mask_i,
    output logic [PW-1:0]    pop_o,
    output logic             all_o,
    output logic             any_o
);

    logic [LANES-1:0] hit;
    logic [LANES-1:0] ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign hit[l] = pred_i[l] & mask_i[l];
        assign ok[l]  = pred_i[l] | ~mask_i[l];
    end

    always_comb begin
        pop_o = '0;
        for (int l = 0; l < LANES; l++) begin
            pop_o = pop_o + PW'(hit[l]);
        end
    end

    assign all_o = &ok;
    assign any_o = |hit;

endmodule

// File: rtl/wbr_arrival_track.sv
module wbr_arrival_track #(
    parameter int MAX_WARPS = 32,
    localparam int IDW      = $clog2(MAX_WARPS),
    localparam int WW       = $clog2(MAX_WARPS + 1)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           launch_i,
    input  logic [WW-1:0]  launch_warps_i,
    input  logic           arr_valid_i,
    input  logic [IDW-1:0] arr_warp_i,
    output logic           accept_o,
    output logic           dup_o,
    output logic           last_o
);

    typedef struct packed {
        logic [MAX_WARPS-1:0] seen;
        logic [WW-1:0]        cnt;
        logic [WW-1:0]        limit;
    } trk_t;

    trk_t trk_d, trk_q;
    logic in_range;
    logic already;

    assign in_range = WW'(arr_warp_i) < trk_q.limit;
    assign already  = trk_q.seen[arr_warp_i];

    always_comb begin
        trk_d    = trk_q;
        accept_o = 1'b0;
        dup_o    = 1'b0;
        last_o   = 1'b0;
        if (launch_i) begin
            trk_d.seen = '0;
            trk_d.cnt  = '0;
            if (launch_warps_i == '0) begin
                trk_d.limit = WW'(1);
            end else if (launch_warps_i > WW'(MAX_WARPS)) begin
                trk_d.limit = WW'(MAX_WARPS);
            end else begin
                trk_d.limit = launch_warps_i;
            end
        end else if (arr_valid_i && in_range) begin
            if (already) begin
                dup_o = 1'b1;
            end else begin
                accept_o = 1'b1;
                if (trk_q.cnt + WW'(1) == trk_q.limit) begin
                    last_o     = 1'b1;
                    trk_d.seen = '0;
                    trk_d.cnt  = '0;
                end else begin
                    trk_d.seen[arr_warp_i] = 1'b1;
                    trk_d.cnt              = trk_q.cnt + WW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q.seen  <= '0;
            trk_q.cnt   <= '0;
            trk_q.limit <= WW'(MAX_WARPS);
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_q.cnt < trk_q.limit); // R2

    AST_SEEN_MATCHES_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(trk_q.seen) == int'(trk_q.cnt)); // R8

endmodule

// File: rtl/warp_barrier_reduce.sv
module warp_barrier_reduce
    import wbr_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int MAX_WARPS = 32,
    localparam int IDW      = $clog2(MAX_WARPS),
    localparam int WW       = $clog2(MAX_WARPS + 1),
    localparam int PW       = $clog2(LANES + 1),
    localparam int CW       = $clog2(MAX_WARPS * LANES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             launch_i,
    input  logic [WW-1:0]    launch_warps_i,
    input  logic             arr_valid_i,
    input  logic [IDW-1:0]   arr_warp_i,
    input  logic [1:0]       arr_mode_i,
    input  logic [LANES-1:0] arr_pred_i,
    input  logic [LANES-1:0] arr_mask_i,
    output logic             release_o,
    output logic [CW-1:0]    result_o,
    output logic             mismatch_o,
    output logic             dup_o
);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          all_ok;
        logic          any_hit;
        wbr_kind_e     kind;
        logic          busy;
        logic          mism;
        logic          dup;
        logic          rel;
        logic [CW-1:0] res;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [PW-1:0] w_pop;
    logic          w_all, w_any;
    logic          accept, dup_hit, last;

    wbr_lane_fold #(.LANES(LANES)) u_fold (
        .pred_i (arr_pred_i),
        .mask_i (arr_mask_i),
        .pop_o  (w_pop),
        .all_o  (w_all),
        .any_o  (w_any)
    );

    wbr_arrival_track #(.MAX_WARPS(MAX_WARPS)) u_track (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .launch_i       (launch_i),
        .launch_warps_i (launch_warps_i),
        .arr_valid_i    (arr_valid_i),
        .arr_warp_i     (arr_warp_i),
        .accept_o       (accept),
        .dup_o          (dup_hit),
        .last_o         (last)
    );

    wbr_kind_e     in_kind, eff_kind;
    logic [CW-1:0] cnt_new;
    logic          all_new, any_new;

    always_comb begin
        in_kind  = wbr_kind_e'(arr_mode_i);
        eff_kind = acc_q.busy ? acc_q.kind : in_kind;
        cnt_new  = acc_q.count + CW'(w_pop);
        all_new  = acc_q.all_ok & w_all;
        any_new  = acc_q.any_hit | w_any;

        acc_d     = acc_q;
        acc_d.rel = 1'b0;
        acc_d.res = '0;
        if (launch_i) begin
            acc_d.count   = '0;
            acc_d.all_ok  = 1'b1;
            acc_d.any_hit = 1'b0;
            acc_d.kind    = WBR_COUNT;
            acc_d.busy    = 1'b0;
            acc_d.mism    = 1'b0;
            acc_d.dup     = 1'b0;
        end else if (dup_hit) begin
            acc_d.dup = 1'b1;
        end else if (accept) begin
            if (acc_q.busy && in_kind != acc_q.kind) begin
                acc_d.mism = 1'b1;
            end
            if (last) begin
                acc_d.rel = 1'b1;
                unique case (eff_kind)
                    WBR_ALL: acc_d.res = CW'(all_new);
                    WBR_ANY: acc_d.res = CW'(any_new);
                    default: acc_d.res = cnt_new;
                endcase
                acc_d.count   = '0;
                acc_d.all_ok  = 1'b1;
                acc_d.any_hit = 1'b0;
                acc_d.kind    = WBR_COUNT;
                acc_d.busy    = 1'b0;
            end else begin
                acc_d.count   = cnt_new;
                acc_d.all_ok  = all_new;
                acc_d.any_hit = any_new;
                acc_d.kind    = eff_kind;
                acc_d.busy    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q.count   <= '0;
            acc_q.all_ok  <= 1'b1;
            acc_q.any_hit <= 1'b0;
            acc_q.kind    <= WBR_COUNT;
            acc_q.busy    <= 1'b0;
            acc_q.mism    <= 1'b0;
            acc_q.dup     <= 1'b0;
            acc_q.rel     <= 1'b0;
            acc_q.res     <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign release_o  = acc_q.rel;
    assign result_o   = acc_q.res;
    assign mismatch_o = acc_q.mism;
    assign dup_o      = acc_q.dup;

    AST_RELEASE_NEEDS_ARRIVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o |-> $past(arr_valid_i && !launch_i)); // R2

    AST_RESULT_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !release_o |-> result_o == '0); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(result_o) <= MAX_WARPS * LANES); // R3

    AST_MISMATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mismatch_o && !launch_i) |=> mismatch_o); // R7

    AST_DUP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dup_o && !launch_i) |=> dup_o); // R8

    AST_LAUNCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_i |=> (!mismatch_o && !dup_o && !release_o)); // R6

endmodule

// File: tb/warp_barrier_reduce_tb.sv
`timescale 1ns/1ps
module warp_barrier_reduce_tb;

    localparam int LANES     = 4;
    localparam int MAX_WARPS = 4;
    localparam int IDW       = $clog2(MAX_WARPS);
    localparam int WW        = $clog2(MAX_WARPS + 1);
    localparam int CW        = $clog2(MAX_WARPS * LANES + 1);
    localparam int LMASK     = (1 << LANES) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             launch = 1'b0;
    logic [WW-1:0]    launch_warps = '0;
    logic             arr_valid = 1'b0;
    logic [IDW-1:0]   arr_warp = '0;
    logic [1:0]       arr_mode = '0;
    logic [LANES-1:0] arr_pred = '0;
    logic [LANES-1:0] arr_mask = '0;
    logic             release_w;
    logic [CW-1:0]    result_w;
    logic             mismatch_w, dup_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    warp_barrier_reduce #(.LANES(LANES), .MAX_WARPS(MAX_WARPS)) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .launch_i       (launch),
        .launch_warps_i (launch_warps),
        .arr_valid_i    (arr_valid),
        .arr_warp_i     (arr_warp),
        .arr_mode_i     (arr_mode),
        .arr_pred_i     (arr_pred),
        .arr_mask_i     (arr_mask),
        .release_o      (release_w),
        .result_o       (result_w),
        .mismatch_o     (mismatch_w),
        .dup_o          (dup_w)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic int popc(input int v);
        int n = 0;
        for (int i = 0; i < LANES; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic step(input bit v, input int w, input int p, input int m, input int md);
        @(negedge clk);
        launch    = 1'b0;
        arr_valid = v;
        arr_warp  = IDW'(w);
        arr_pred  = LANES'(p);
        arr_mask  = LANES'(m);
        arr_mode  = 2'(md);
    endtask

    task automatic do_launch(input int n);
        @(negedge clk);
        arr_valid    = 1'b0;
        launch       = 1'b1;
        launch_warps = WW'(n);
        @(negedge clk);
        launch = 1'b0;
    endtask

    function automatic int pick(input int md, input int cnt, input bit all_ok, input bit any_hit);
        if (md == 1) return int'(all_ok);
        if (md == 2) return int'(any_hit);
        return cnt;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_eq("R1 release", int'(release_w), 0);
        chk_eq("R1 result", int'(result_w), 0);
        chk_eq("R1 mismatch", int'(mismatch_w), 0);
        chk_eq("R1 dup", int'(dup_w), 0);
        rst_n = 1'b1;
        // R1: default count is MAX_WARPS; three arrivals must not release
        step(1, 0, 1, 15, 0); step(1, 1, 1, 15, 0); step(1, 2, 1, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R1 no release before MAX_WARPS", int'(release_w), 0);
        step(1, 3, 1, 15, 0); step(0, 0, 0, 0, 0);
        chk_eq("R1 release at MAX_WARPS", int'(release_w), 1);
        chk_eq("R3 reset count result", int'(result_w), 4);

        // R3 R4 R5: two-warp sweep over every pattern of warp 0
        for (int md = 0; md < 4; md++) begin
            do_launch(2);
            for (int p0 = 0; p0 < 16; p0++) begin
                for (int m0 = 0; m0 < 16; m0++) begin
                    int p1, m1, exp;
                    bit a, y;
                    p1 = (p0 * 5 + 3) & LMASK;
                    m1 = (m0 * 7 + md) & LMASK;
                    a = (((p0 | ~m0) & LMASK) == LMASK) && (((p1 | ~m1) & LMASK) == LMASK);
                    y = ((p0 & m0) | (p1 & m1)) != 0;
                    exp = pick(md, popc(p0 & m0) + popc(p1 & m1), a, y);
                    step(1, 0, p0, m0, md);
                    step(1, 1, p1, m1, md);
                    chk_eq("R2 no early release", int'(release_w), 0);
                    step(0, 0, 0, 0, 0);
                    chk_eq("R2 release after last", int'(release_w), 1);
                    if (md == 1) chk_eq("R4 all result", int'(result_w), exp);
                    else if (md == 2) chk_eq("R5 any result", int'(result_w), exp);
                    else chk_eq("R3 count result", int'(result_w), exp);
                end
            end
        end

        // R2 R3: four warps in reverse order, pulse lasts one cycle
        do_launch(4);
        for (int i = 0; i < 16; i++) begin
            int md, cnt, exp;
            bit a, y;
            md = i % 3; cnt = 0; a = 1'b1; y = 1'b0;
            for (int w = 3; w >= 0; w--) begin
                int p, m;
                p = (i * 3 + w * 5) & LMASK;
                m = (i + w * 6) & LMASK;
                cnt += popc(p & m);
                a &= ((p | ~m) & LMASK) == LMASK;
                y |= (p & m) != 0;
                step(1, w, p, m, md);
                if (w < 3) chk_eq("R2 wait for all four", int'(release_w), 0);
            end
            exp = pick(md, cnt, a, y);
            step(0, 0, 0, 0, 0);
            chk_eq("R2 four-warp release", int'(release_w), 1);
            chk_eq("R3 four-warp result", int'(result_w), exp);
            step(0, 0, 0, 0, 0);
            chk_eq("R2 pulse one cycle", int'(release_w), 0);
            chk_eq("R2 result zero idle", int'(result_w), 0);
        end

        // R9: arrival during release cycle counts toward next barrier
        do_launch(2);
        step(1, 0, 3, 15, 0);
        step(1, 1, 1, 15, 0);
        step(1, 0, 15, 15, 0);
        chk_eq("R9 first release", int'(release_w), 1);
        chk_eq("R9 first result", int'(result_w), 3);
        step(1, 1, 7, 5, 0);
        chk_eq("R9 no release mid", int'(release_w), 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R9 second release", int'(release_w), 1);
        chk_eq("R9 second result", int'(result_w), 6);

        // R8: duplicate arrival ignored and flagged
        do_launch(3);
        step(1, 0, 15, 15, 0);
        step(1, 0, 15, 15, 0);
        step(1, 1, 1, 15, 0);
        chk_eq("R8 dup flag", int'(dup_w), 1);
        step(0, 0, 0, 0, 0);
        chk_eq("R8 dup does not complete", int'(release_w), 0);
        step(1, 2, 0, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R8 release after third", int'(release_w), 1);
        chk_eq("R8 dup not accumulated", int'(result_w), 5);
        chk_eq("R8 dup sticky", int'(dup_w), 1);

        // R7: kind mismatch, first kind wins
        do_launch(2);
        chk_eq("R6 launch clears dup", int'(dup_w), 0);
        step(1, 0, 15, 15, 1);
        step(1, 1, 0, 15, 2);
        step(0, 0, 0, 0, 0);
        chk_eq("R7 mismatch flag", int'(mismatch_w), 1);
        chk_eq("R7 first kind used", int'(result_w), 0);
        chk_eq("R7 still releases", int'(release_w), 1);
        step(0, 0, 0, 0, 0);
        chk_eq("R7 mismatch sticky", int'(mismatch_w), 1);

        // R10: out-of-range warp ignored
        do_launch(2);
        chk_eq("R6 launch clears mismatch", int'(mismatch_w), 0);
        step(1, 3, 15, 15, 0);
        step(1, 0, 1, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R10 no release from out-of-range", int'(release_w), 0);
        step(1, 1, 3, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R10 release", int'(release_w), 1);
        chk_eq("R10 result excludes ignored warp", int'(result_w), 3);

        // R6: clamping and clearing
        do_launch(0);
        step(1, 0, 7, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R6 zero clamps to one", int'(release_w), 1);
        chk_eq("R6 zero clamp result", int'(result_w), 3);
        do_launch(7);
        step(1, 0, 1, 15, 0); step(1, 1, 1, 15, 0); step(1, 2, 1, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R6 high clamp waits", int'(release_w), 0);
        step(1, 3, 1, 15, 0); step(0, 0, 0, 0, 0);
        chk_eq("R6 high clamp releases", int'(release_w), 1);
        do_launch(2);
        step(1, 0, 15, 15, 0);
        do_launch(2);
        step(1, 1, 1, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R6 launch discards pending", int'(release_w), 0);
        @(negedge clk);
        launch = 1'b1; launch_warps = WW'(2);
        arr_valid = 1'b1; arr_warp = '0; arr_pred = 4'hF; arr_mask = 4'hF; arr_mode = 2'b00;
        step(1, 1, 3, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R6 arrival with launch ignored", int'(release_w), 0);
        step(1, 0, 1, 15, 0);
        step(0, 0, 0, 0, 0);
        chk_eq("R6 release after relaunch", int'(release_w), 1);
        chk_eq("R6 result after relaunch", int'(result_w), 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule